// File: doc/BRIEF.md
# Run-Cycle Profiling Counter

This block measures how long a processor spends in run mode. It holds a 32-bit counter that advances by one on every clock cycle in which software has armed it and the processor is in run mode. The processor counts as in run mode while it is executing, while it is stalled waiting for an instruction fetch after a cache miss, and while it sleeps, so stall and sleep cycles land in the total too. Software arms the counter with a start strobe and disarms it with a separate stop strobe. Both strobes live in one control word.

When the counter rolls over from all ones to zero, a sticky overflow flag is set. This flag drives a level request on interrupt line 7 of a small request vector, and it stays set until someone writes the counter. Two agents reach the counter through identical single-cycle register ports: the local core and an external bus master. A port read returns its data combinationally. At most one write is accepted per cycle, and the external master has fixed priority.

Each port has a one-bit address. Address 0 selects the counter, which can be read and written. Address 1 selects the control/status word. On a write to it, bit 0 is the start strobe and bit 1 is the stop strobe. On a read of it, bit 0 is the armed state, bit 1 is the overflow flag, and all higher bits are zero.

Top module: `runcyc_prof`

## Requirements
- R1: While armed, the counter adds one at each clock edge at which at least one of core_exec, core_stall or core_sleep is high. Otherwise it holds its value. The counter is read at address 0.
- R2: A stall cycle (core_stall high) or a sleep cycle (core_sleep high) is counted even when core_exec is low.
- R3: A write to address 1 changes the armed state (status bit 0) from the next cycle on. Bit 0 = 1 with bit 1 = 0 arms the counter. Bit 1 = 1 with bit 0 = 0 disarms it. Both bits at 1, or both at 0, leave the armed state as it was. The strobes are not stored.
- R4: An increment that carries the counter from 32'hFFFFFFFF to 0 sets the overflow flag (status bit 1). The flag then stays set while the counter keeps counting.
- R5: A write to address 0 loads the written value and clears the overflow flag. It overrides an increment in the same cycle, including one that would roll over.
- R6: irq_vec bit 7 equals the overflow flag at all times, and every other bit of irq_vec is 0.
- R7: When both ports write in the same cycle, only the external master's write takes effect and the core's write is discarded. This holds even when the two writes target different addresses.
- R8: After reset the counter is 0, the counter is disarmed, the overflow flag is clear and irq_vec is 0.
- R9: In a control write, bits 31:2 are ignored. A control write never changes the counter value beyond the normal R1 increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_exec | input | 1 | Processor is executing instructions |
| core_stall | input | 1 | Processor is stalled on an instruction cache miss |
| core_sleep | input | 1 | Processor is asleep |
| core_we | input | 1 | Local core write enable |
| core_addr | input | 1 | Local core register select (0 counter, 1 control/status) |
| core_wdata | input | 32 | Local core write data |
| core_rdata | output | 32 | Local core read data |
| ext_we | input | 1 | External master write enable |
| ext_addr | input | 1 | External master register select |
| ext_wdata | input | 32 | External master write data |
| ext_rdata | output | 32 | External master read data |
| irq_vec | output | 8 | Interrupt request lines; bit 7 carries overflow |

## Verification
Rolling the counter over by counting from zero would take more than four billion cycles, which is out of reach. The stimulus instead loads values a few counts below all ones through the write ports and then lets the counter run across the boundary. The hardest corner is a counter write that lands in the same cycle as a rollover; in that case the write must win and the flag must stay clear. The directed sequence stages this case deliberately. The random phase also makes near-maximum loads frequent, so that wraps, sticky-flag runs and same-cycle collisions between the two ports happen many times.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

  // register select carried by each port's one-bit address
  typedef enum logic {
    RCP_SEL_COUNT = 1'b0,
    RCP_SEL_CTRL  = 1'b1
  } rcp_sel_e;

  // control word written at address 1
  localparam int RCP_BIT_GO   = 0;
  localparam int RCP_BIT_HALT = 1;

  // status word read at address 1
  localparam int RCP_BIT_ARMED = 0;
  localparam int RCP_BIT_OVF   = 1;

  // armed-state update: a lone go arms, a lone halt disarms, else hold
  function automatic logic rcp_next_armed(input logic cur, input logic go, input logic halt);
    logic nxt;
    unique case ({go, halt})
      2'b10:   nxt = 1'b1;
      2'b01:   nxt = 1'b0;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

  // a cycle belongs to run mode when executing, stalled on a fetch, or asleep
  function automatic logic rcp_in_run(input logic exec, input logic stall, input logic sleep);
    return exec | stall | sleep;
  endfunction

endpackage

// File: rtl/rcp_wr_arb.sv
module rcp_wr_arb #(
  parameter int W = 32
) (
  input  logic         core_we,
  input  logic         core_addr,
  input  logic [W-1:0] core_wdata,
  input  logic         ext_we,
  input  logic         ext_addr,
  input  logic [W-1:0] ext_wdata,
  output logic         wr_vld,
  output logic         wr_addr,
  output logic [W-1:0] wr_data,
  output logic         wr_src_ext,
  output logic         core_dropped
);

  // fixed priority: the external master always wins a shared cycle
  always_comb begin
    wr_vld       = ext_we | core_we;
    wr_src_ext   = ext_we;
    core_dropped = ext_we & core_we;
    if (ext_we) begin
      wr_addr = ext_addr;
      wr_data = ext_wdata;
    end else begin
      wr_addr = core_addr;
      wr_data = core_wdata;
    end
  end

endmodule

// File: rtl/rcp_run_ctrl.sv
module rcp_run_ctrl
  import rcp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic go_bit,
  input  logic halt_bit,
  output logic armed,
  output logic go_evt,
  output logic halt_evt
);

  // strobes live for the write cycle only
  assign go_evt   = ctrl_wr & go_bit;
  assign halt_evt = ctrl_wr & halt_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= rcp_next_armed(armed, go_evt, halt_evt);
    end
  end

endmodule

// File: rtl/rcp_cnt_core.sv
module rcp_cnt_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         ovf,
  output logic         wrap_evt
);

  logic         carry;
  logic [W-1:0] count_inc;

  assign {carry, count_inc} = {1'b0, count} + {{W{1'b0}}, 1'b1};
  // a rollover only counts when no load overrides it
  assign wrap_evt = inc_en & carry & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (load) begin
      count <= load_val;
      ovf   <= 1'b0;
    end else if (inc_en) begin
      count <= count_inc;
      if (carry) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/rcp_rd_mux.sv
module rcp_rd_mux
  import rcp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         addr,
  input  logic [W-1:0] count,
  input  logic         armed,
  input  logic         ovf,
  output logic [W-1:0] rdata
);

  logic [W-1:0] status;

  always_comb begin
    status                = '0;
    status[RCP_BIT_ARMED] = armed;
    status[RCP_BIT_OVF]   = ovf;
  end

  assign rdata = (rcp_sel_e'(addr) == RCP_SEL_CTRL) ? status : count;

endmodule

// File: rtl/runcyc_prof.sv
module runcyc_prof
  import rcp_pkg::*;
#(
  parameter int W         = 32,
  parameter int IRQ_LINES = 8,
  parameter int IRQ_SEL   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 core_exec,
  input  logic                 core_stall,
  input  logic                 core_sleep,
  input  logic                 core_we,
  input  logic                 core_addr,
  input  logic [W-1:0]         core_wdata,
  output logic [W-1:0]         core_rdata,
  input  logic                 ext_we,
  input  logic                 ext_addr,
  input  logic [W-1:0]         ext_wdata,
  output logic [W-1:0]         ext_rdata,
  output logic [IRQ_LINES-1:0] irq_vec
);

  localparam int NPORT = 2;

  // named internal events, also observed by the bound checker
  logic         wr_vld;
  logic         wr_addr;
  logic [W-1:0] wr_data;
  logic         wr_src_ext;
  logic         core_dropped;
  logic         cnt_load;
  logic         ctrl_wr;
  logic         armed;
  logic         go_evt;
  logic         halt_evt;
  logic         in_run;
  logic         inc_en;
  logic [W-1:0] count;
  logic         ovf;
  logic         wrap_evt;

  rcp_wr_arb #(.W(W)) u_arb (
    .core_we      (core_we),
    .core_addr    (core_addr),
    .core_wdata   (core_wdata),
    .ext_we       (ext_we),
    .ext_addr     (ext_addr),
    .ext_wdata    (ext_wdata),
    .wr_vld       (wr_vld),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .wr_src_ext   (wr_src_ext),
    .core_dropped (core_dropped)
  );

  assign cnt_load = wr_vld & (rcp_sel_e'(wr_addr) == RCP_SEL_COUNT);
  assign ctrl_wr  = wr_vld & (rcp_sel_e'(wr_addr) == RCP_SEL_CTRL);

  rcp_run_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .go_bit   (wr_data[RCP_BIT_GO]),
    .halt_bit (wr_data[RCP_BIT_HALT]),
    .armed    (armed),
    .go_evt   (go_evt),
    .halt_evt (halt_evt)
  );

  assign in_run = rcp_in_run(core_exec, core_stall, core_sleep);
  assign inc_en = armed & in_run;

  rcp_cnt_core #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (inc_en),
    .load     (cnt_load),
    .load_val (wr_data),
    .count    (count),
    .ovf      (ovf),
    .wrap_evt (wrap_evt)
  );

  // one read mux per agent
  logic [NPORT-1:0]        rd_addr;
  logic [NPORT-1:0][W-1:0] rd_data;

  assign rd_addr = {ext_addr, core_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    rcp_rd_mux #(.W(W)) u_rd (
      .addr  (rd_addr[p]),
      .count (count),
      .armed (armed),
      .ovf   (ovf),
      .rdata (rd_data[p])
    );
  end

  assign core_rdata = rd_data[0];
  assign ext_rdata  = rd_data[1];

  // overflow drives its fixed request line as a level
  for (genvar l = 0; l < IRQ_LINES; l++) begin : g_irq
    if (l == IRQ_SEL) begin : g_hit
      assign irq_vec[l] = ovf;
    end else begin : g_idle
      assign irq_vec[l] = 1'b0;
    end
  end

endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
  parameter int W         = 32,
  parameter int IRQ_LINES = 8,
  parameter int IRQ_SEL   = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 core_we,
  input logic                 ext_we,
  input logic                 core_stall,
  input logic                 core_sleep,
  input logic                 wr_src_ext,
  input logic                 cnt_load,
  input logic [W-1:0]         wr_data,
  input logic                 armed,
  input logic                 go_evt,
  input logic                 halt_evt,
  input logic                 inc_en,
  input logic [W-1:0]         count,
  input logic                 ovf,
  input logic                 wrap_evt,
  input logic [IRQ_LINES-1:0] irq_vec
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_en && !cnt_load) |=> $stable(count));

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !cnt_load) |=> (count == $past(count) + 1'b1));

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (core_stall || core_sleep)) |-> inc_en);

  p_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_evt && !halt_evt) |=> armed);

  p_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_evt && !go_evt) |=> !armed);

  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go_evt == halt_evt) |=> (armed == $past(armed)));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (ovf && count == '0));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cnt_load) |=> ovf);

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> ((count == $past(wr_data)) && !ovf));

  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (irq_vec[IRQ_SEL] && $onehot0(irq_vec)));

  p_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> (irq_vec == '0));

  p_arb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && core_we) |-> wr_src_ext);

endmodule

bind runcyc_prof rcp_checker #(.W(W), .IRQ_LINES(IRQ_LINES), .IRQ_SEL(IRQ_SEL)) u_rcp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_we    (core_we),
  .ext_we     (ext_we),
  .core_stall (core_stall),
  .core_sleep (core_sleep),
  .wr_src_ext (wr_src_ext),
  .cnt_load   (cnt_load),
  .wr_data    (wr_data),
  .armed      (armed),
  .go_evt     (go_evt),
  .halt_evt   (halt_evt),
  .inc_en     (inc_en),
  .count      (count),
  .ovf        (ovf),
  .wrap_evt   (wrap_evt),
  .irq_vec    (irq_vec)
);

// File: tb/runcyc_prof_test.sv
module runcyc_prof_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_exec = 1'b0, core_stall = 1'b0, core_sleep = 1'b0;
  logic        core_we = 1'b0, core_addr = 1'b0;
  logic [31:0] core_wdata = '0;
  logic [31:0] core_rdata;
  logic        ext_we = 1'b0, ext_addr = 1'b0;
  logic [31:0] ext_wdata = '0;
  logic [31:0] ext_rdata;
  logic [7:0]  irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_cnt = '0;
  logic        m_arm = 1'b0;
  logic        m_ovf = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  runcyc_prof uut (
    .clk(clk), .rst_n(rst_n),
    .core_exec(core_exec), .core_stall(core_stall), .core_sleep(core_sleep),
    .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
    .ext_we(ext_we), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .irq_vec(irq_vec)
  );

  function automatic logic [31:0] exp_status(input logic arm, input logic ov);
    return {30'b0, ov, arm};
  endfunction

  function automatic logic exp_arm(input logic cur, input logic [31:0] wd);
    if (wd[0] && !wd[1]) return 1'b1;
    if (wd[1] && !wd[0]) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // read both registers through both ports and the interrupt vector
  task automatic observe(input string tag);
    core_we = 1'b0; ext_we = 1'b0;
    core_addr = 1'b0; ext_addr = 1'b1;
    #1;
    chk(tag, "core count", core_rdata, m_cnt);
    chk(tag, "ext status", ext_rdata, exp_status(m_arm, m_ovf));
    chk("R6", "irq_vec", {24'b0, irq_vec}, {24'b0, m_ovf, 7'b0});
    core_addr = 1'b1; ext_addr = 1'b0;
    #1;
    chk(tag, "ext count", ext_rdata, m_cnt);
    chk(tag, "core status", core_rdata, exp_status(m_arm, m_ovf));
  endtask

  // drive one cycle at a negedge, update the model at the posedge, check at the next negedge
  task automatic step(input string tag, input logic ex, input logic st, input logic sl,
                      input logic cwe, input logic ca, input logic [31:0] cwd,
                      input logic ewe, input logic ea, input logic [31:0] ewd);
    logic        wv, wa, inc;
    logic [31:0] wd;
    core_exec = ex; core_stall = st; core_sleep = sl;
    core_we = cwe; core_addr = ca; core_wdata = cwd;
    ext_we = ewe; ext_addr = ea; ext_wdata = ewd;
    wv = ewe | cwe;
    wa = ewe ? ea : ca;
    wd = ewe ? ewd : cwd;
    inc = m_arm & (ex | st | sl);
    @(posedge clk);
    if (wv && !wa) begin
      m_cnt = wd;
      m_ovf = 1'b0;
    end else if (inc) begin
      if (m_cnt == 32'hFFFF_FFFF) m_ovf = 1'b1;
      m_cnt = m_cnt + 32'd1;
    end
    if (wv && wa) m_arm = exp_arm(m_arm, wd);
    @(negedge clk);
    observe(tag);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd914237);
    repeat (3) @(negedge clk);
    observe("R8");
    rst_n = 1'b1;
    @(negedge clk);
    observe("R8");

    // not armed: no counting
    step("R1", 1,0,0, 0,0,0, 0,0,0);
    // arm through the external port
    step("R3", 1,0,0, 0,0,0, 1,1,32'h1);
    step("R1", 1,0,0, 0,0,0, 0,0,0);
    step("R2", 0,1,0, 0,0,0, 0,0,0);
    step("R2", 0,0,1, 0,0,0, 0,0,0);
    step("R1", 0,0,0, 0,0,0, 0,0,0);
    // both strobes: unchanged; then stop; then both while stopped
    step("R3", 1,0,0, 1,1,32'h3, 0,0,0);
    step("R3", 1,0,0, 1,1,32'h2, 0,0,0);
    step("R3", 1,0,0, 0,0,0, 0,0,0);
    step("R3", 1,0,0, 0,0,0, 1,1,32'h3);
    // upper control bits are ignored
    step("R9", 1,0,0, 1,1,32'hFFFF_FFFC, 0,0,0);
    step("R3", 1,0,0, 1,1,32'h1, 0,0,0);
    step("R9", 1,0,0, 0,0,0, 1,1,32'hFFFF_FFFC);
    // load near the top and roll over
    step("R5", 1,0,0, 1,0,32'hFFFF_FFFE, 0,0,0);
    step("R4", 1,0,0, 0,0,0, 0,0,0);
    step("R4", 0,1,0, 0,0,0, 0,0,0);
    step("R4", 1,0,0, 0,0,0, 0,0,0);
    step("R4", 0,0,0, 0,0,0, 0,0,0);
    // counter write clears the sticky flag
    step("R5", 1,0,0, 0,0,0, 1,0,32'h10);
    // write in the same cycle as a would-be rollover
    step("R5", 1,0,0, 1,0,32'hFFFF_FFFF, 0,0,0);
    step("R5", 1,0,0, 1,0,32'h5, 0,0,0);
    // port collisions
    step("R7", 1,0,0, 1,0,32'h0000_AAAA, 1,0,32'h0000_5555);
    step("R7", 1,0,0, 1,0,32'h0000_0077, 1,1,32'h2);
    step("R7", 1,0,0, 1,1,32'h1, 1,0,32'hFFFF_FFFD);
    step("R7", 1,0,0, 0,0,0, 0,0,0);

    // random phase, near-top loads made frequent
    for (int i = 0; i < 3000; i++) begin
      logic        ex, st, sl, cwe, ca, ewe, ea;
      logic [31:0] cwd, ewd;
      ex  = ($urandom % 3) != 0;
      st  = ($urandom % 5) == 0;
      sl  = ($urandom % 6) == 0;
      cwe = ($urandom % 6) == 0;
      ewe = ($urandom % 8) == 0;
      ca  = ($urandom % 3) == 0;
      ea  = ($urandom % 3) == 0;
      cwd = (($urandom % 2) == 0) ? (32'hFFFF_FFF0 | ($urandom % 16)) : $urandom;
      ewd = (($urandom % 2) == 0) ? (32'hFFFF_FFF8 | ($urandom % 8)) : $urandom;
      if (ca) cwd = (($urandom % 4) == 0) ? 32'h2 : 32'h1;
      if (ea) ewd = $urandom % 4;
      step("R1", ex, st, sl, cwe, ca, cwd, ewe, ea, ewd);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule